// File: doc/BRIEF.md
# Transmit Descriptor Walker

The walker builds one outgoing Ethernet frame from a ring of two-word transmit descriptors in memory and streams it, one byte per valid cycle, to the MAC transmitter. Software writes the ring base into the queue pointer, fills in descriptors and buffers, and pulses `start`. The walker then reads descriptors one after another. It gathers the bytes of each buffer in address order and moves on until it finds a descriptor that marks the end of the frame.

When the frame asks for automatic CRC, the walker adds zero bytes until the frame holds 60 bytes. It then appends the 32-bit FCS, so the frame on the wire is at least 64 bytes long. Longer frames pass through whole. Each descriptor that is consumed gets its used flag written back to memory. The queue pointer moves to the next descriptor, or back to the ring base when the wrap flag is set. At the end of every attempt the walker reports a one-cycle completion code.

Top module: `txdesc_walker`

## Requirements
- R1: A descriptor is two 32-bit words at pointer P and P+4. Word 0 is the byte address of the buffer. Bytes are sent in rising address order, starting at that address, which may be unaligned; memory words are little-endian (the byte at address A sits in bits 8*(A mod 4)+7 .. 8*(A mod 4)). Buffers are joined in descriptor order.
- R2: Word 1 bits [10:0] give the buffer length, from 0 to 2047. A zero-length buffer adds no byte to the stream, and a frame made only of zero-length buffers without CRC emits no byte at all.
- R3: Word 1 bit 15 marks the final buffer. `tx_last` is high together with `tx_valid` on exactly one byte per completed frame, the final one.
- R4: Word 1 bit 16 of the first descriptor of a frame turns off automatic CRC. The frame is then exactly the buffer bytes, with no padding and no FCS.
- R5: With automatic CRC on, the walker pads the data with 0x00 bytes up to 60 bytes. It then appends the IEEE 802.3 CRC-32 of all preceding bytes, least significant byte first. Data of 60 bytes or more is neither padded nor cut.
- R6: For every descriptor consumed, word 1 is written back unchanged except that bit 31 (used) is set.
- R7: After a descriptor, the queue pointer becomes the ring base if word 1 bit 30 is set, and the descriptor address plus 8 otherwise. `qptr_rdata` shows the pointer while idle.
- R8: If the first descriptor of an attempt already has bit 31 set, the walker reports code 1 (empty), emits no byte and leaves the queue pointer unchanged.
- R9: If a descriptor with bit 31 set is reached after the first buffer of a frame, the walker reports code 2 (underrun). It never raises `tx_last` for that frame and resets the queue pointer to the ring base.
- R10: A frame may use at most MAX_BUF (128) buffers. Reaching an unused descriptor after that many reports code 3 (over limit), and a frame of exactly 128 buffers completes with code 0.
- R11: After reset `tx_valid`, `tx_last`, `stat_valid`, `busy` are low and the queue pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qptr_wr | input | 1 | Write ring base and queue pointer (accepted while idle) |
| qptr_wdata | input | 32 | New ring base, 8-byte aligned |
| qptr_rdata | output | 32 | Current queue pointer |
| start | input | 1 | Begin transmitting one frame |
| busy | output | 1 | Walker is working on a frame |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Word-aligned read byte address |
| mem_rd_data | input | 32 | Read data, one cycle after the request |
| mem_wr_en | output | 1 | Descriptor write-back strobe |
| mem_wr_addr | output | 32 | Write-back byte address |
| mem_wr_data | output | 32 | Write-back word |
| tx_valid | output | 1 | Byte valid towards the MAC |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| stat_valid | output | 1 | One-cycle completion strobe |
| stat_code | output | 2 | 0 ok, 1 empty, 2 underrun, 3 over limit |

## Verification
A wrong byte-lane offset or a missed word refetch shows up at once in the stream: a byte is repeated or out of order within the first four bytes after a buffer boundary. A wrong frame byte count does not show in the data itself. It appears only at the end of the frame, as a wrong pad length and then an FCS mismatch. A wrong buffer counter shows only at the 128/129 descriptor boundary, or as a wrong code when a used descriptor is met. A stale pointer shows at `qptr_rdata` as soon as the walker is idle again.

// File: rtl/txw_pkg.sv
package txw_pkg;
  localparam int W1_LAST  = 15;
  localparam int W1_NOCRC = 16;
  localparam int W1_WRAP  = 30;
  localparam int W1_USED  = 31;

  typedef enum logic [1:0] {
    ST_OK        = 2'd0,
    ST_EMPTY     = 2'd1,
    ST_UNDERRUN  = 2'd2,
    ST_OVERLIMIT = 2'd3
  } txw_stat_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
endpackage

// File: rtl/txw_crc32.sv
module txw_crc32
  import txw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [31:0] crc_q
);
  function automatic logic [31:0] step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clr) crc_q <= 32'hFFFF_FFFF;
    else if (upd)   crc_q <= step(crc_q, din);
  end
endmodule

// File: rtl/txw_outreg.sv
module txw_outreg (
  input  logic       clk,
  input  logic       rst,
  input  logic       push,
  input  logic [7:0] push_byte,
  input  logic       flush,
  input  logic       drop,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_last
);
  logic       pend_vld;
  logic [7:0] pend_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld  <= 1'b0;
      pend_byte <= 8'h00;
      tx_valid  <= 1'b0;
      tx_data   <= 8'h00;
      tx_last   <= 1'b0;
    end else begin
      tx_valid <= 1'b0;
      tx_last  <= 1'b0;
      if (drop) begin
        pend_vld <= 1'b0;
      end else if (push) begin
        if (pend_vld) begin
          tx_valid <= 1'b1;
          tx_data  <= pend_byte;
        end
        pend_byte <= push_byte;
        pend_vld  <= 1'b1;
      end else if (flush) begin
        if (pend_vld) begin
          tx_valid <= 1'b1;
          tx_last  <= 1'b1;
          tx_data  <= pend_byte;
        end
        pend_vld <= 1'b0;
      end
    end
  end

  a_r3_last_has_valid: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);
  a_r3_push_not_flush: assert property (@(posedge clk) disable iff (rst)
    push |-> !flush);
  a_r3_last_empties: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> !pend_vld);
endmodule

// File: rtl/txdesc_walker.sv
module txdesc_walker
  import txw_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LEN_W     = 11,
  parameter int MAX_BUF   = 128,
  parameter int MIN_FRAME = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          qptr_wr,
  input  logic [AW-1:0] qptr_wdata,
  output logic [AW-1:0] qptr_rdata,
  input  logic          start,
  output logic          busy,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [31:0]   mem_rd_data,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [31:0]   mem_wr_data,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          stat_valid,
  output logic [1:0]    stat_code
);
  localparam int NB_W   = $clog2(MAX_BUF + 1);
  localparam int CNT_W  = LEN_W + NB_W + 1;
  localparam int PAD_TO = MIN_FRAME - 4;

  typedef enum logic [3:0] {
    S_IDLE, S_D0, S_D1, S_D2, S_DEC, S_FETCH, S_LOAD,
    S_EMIT, S_WB, S_PAD, S_FCS, S_FLUSH, S_FIN
  } st_e;

  st_e             st;
  logic [AW-1:0]   base_q, ptr_q, cur_q;
  logic [31:0]     w0_q, w1_q, wbuf_q;
  logic [LEN_W-1:0] rem_q;
  logic [NB_W-1:0] nbuf_q;
  logic [CNT_W-1:0] fcnt_q;
  logic [1:0]      fidx_q;
  logic            nocrc_q, lastbuf_q;
  txw_stat_e       code_q;
  logic            stat_v_q;
  txw_stat_e       stat_c_q;

  logic            prod, crc_upd, crc_clr, flush, drop;
  logic [7:0]      prod_byte;
  logic [31:0]     crc_q;
  logic [31:0]     fcs_word;

  assign fcs_word = ~crc_q;

  always_comb begin
    mem_rd_en   = 1'b0;
    mem_rd_addr = '0;
    prod        = 1'b0;
    prod_byte   = 8'h00;
    crc_upd     = 1'b0;
    unique case (st)
      S_D0:    begin mem_rd_en = 1'b1; mem_rd_addr = ptr_q; end
      S_D1:    begin mem_rd_en = 1'b1; mem_rd_addr = ptr_q + AW'(4); end
      S_FETCH: begin mem_rd_en = 1'b1; mem_rd_addr = {cur_q[AW-1:2], 2'b00}; end
      S_EMIT:  begin prod = 1'b1; crc_upd = 1'b1; prod_byte = wbuf_q[8*cur_q[1:0] +: 8]; end
      S_PAD:   begin prod = 1'b1; crc_upd = 1'b1; prod_byte = 8'h00; end
      S_FCS:   begin prod = 1'b1; prod_byte = fcs_word[8*fidx_q +: 8]; end
      default: ;
    endcase
  end

  assign crc_clr     = (st == S_IDLE) && start;
  assign flush       = (st == S_FLUSH);
  assign drop        = (st == S_DEC) && (w1_q[W1_USED] || (nbuf_q == NB_W'(MAX_BUF)));
  assign mem_wr_en   = (st == S_WB);
  assign mem_wr_addr = ptr_q + AW'(4);
  assign mem_wr_data = {1'b1, w1_q[30:0]};
  assign qptr_rdata  = ptr_q;
  assign busy        = (st != S_IDLE);
  assign stat_valid  = stat_v_q;
  assign stat_code   = stat_c_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      base_q    <= '0;
      ptr_q     <= '0;
      cur_q     <= '0;
      w0_q      <= '0;
      w1_q      <= '0;
      wbuf_q    <= '0;
      rem_q     <= '0;
      nbuf_q    <= '0;
      fcnt_q    <= '0;
      fidx_q    <= '0;
      nocrc_q   <= 1'b0;
      lastbuf_q <= 1'b0;
      code_q    <= ST_OK;
      stat_v_q  <= 1'b0;
      stat_c_q  <= ST_OK;
    end else begin
      stat_v_q <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (qptr_wr) begin
            base_q <= qptr_wdata;
            ptr_q  <= qptr_wdata;
          end
          if (start) begin
            nbuf_q    <= '0;
            fcnt_q    <= '0;
            fidx_q    <= '0;
            lastbuf_q <= 1'b0;
            st        <= S_D0;
          end
        end
        S_D0: st <= S_D1;
        S_D1: begin
          w0_q <= mem_rd_data;
          st   <= S_D2;
        end
        S_D2: begin
          w1_q <= mem_rd_data;
          st   <= S_DEC;
        end
        S_DEC: begin
          if (w1_q[W1_USED]) begin
            code_q <= (nbuf_q == '0) ? ST_EMPTY : ST_UNDERRUN;
            if (nbuf_q != '0) ptr_q <= base_q;
            st <= S_FIN;
          end else if (nbuf_q == NB_W'(MAX_BUF)) begin
            code_q <= ST_OVERLIMIT;
            ptr_q  <= base_q;
            st     <= S_FIN;
          end else begin
            nbuf_q <= nbuf_q + 1'b1;
            if (nbuf_q == '0) nocrc_q <= w1_q[W1_NOCRC];
            cur_q     <= w0_q[AW-1:0];
            rem_q     <= w1_q[LEN_W-1:0];
            lastbuf_q <= w1_q[W1_LAST];
            st        <= (w1_q[LEN_W-1:0] == '0) ? S_WB : S_FETCH;
          end
        end
        S_FETCH: st <= S_LOAD;
        S_LOAD: begin
          wbuf_q <= mem_rd_data;
          st     <= S_EMIT;
        end
        S_EMIT: begin
          cur_q  <= cur_q + 1'b1;
          rem_q  <= rem_q - 1'b1;
          fcnt_q <= fcnt_q + 1'b1;
          if (rem_q == LEN_W'(1))       st <= S_WB;
          else if (cur_q[1:0] == 2'd3)  st <= S_FETCH;
        end
        S_WB: begin
          ptr_q <= w1_q[W1_WRAP] ? base_q : ptr_q + AW'(8);
          if (!lastbuf_q)  st <= S_D0;
          else if (nocrc_q) st <= S_FLUSH;
          else if (fcnt_q < CNT_W'(PAD_TO)) st <= S_PAD;
          else st <= S_FCS;
        end
        S_PAD: begin
          fcnt_q <= fcnt_q + 1'b1;
          if (fcnt_q == CNT_W'(PAD_TO - 1)) st <= S_FCS;
        end
        S_FCS: begin
          fidx_q <= fidx_q + 1'b1;
          if (fidx_q == 2'd3) st <= S_FLUSH;
        end
        S_FLUSH: begin
          code_q <= ST_OK;
          st     <= S_FIN;
        end
        S_FIN: begin
          stat_v_q <= 1'b1;
          stat_c_q <= code_q;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  txw_crc32 u_crc (
    .clk  (clk),
    .rst  (rst),
    .clr  (crc_clr),
    .upd  (crc_upd),
    .din  (prod_byte),
    .crc_q(crc_q)
  );

  txw_outreg u_out (
    .clk      (clk),
    .rst      (rst),
    .push     (prod),
    .push_byte(prod_byte),
    .flush    (flush),
    .drop     (drop),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_last  (tx_last)
  );

  a_r2_emit_has_bytes: assert property (@(posedge clk) disable iff (rst)
    (st == S_EMIT) |-> (rem_q != '0));
  a_r10_buf_bound: assert property (@(posedge clk) disable iff (rst)
    nbuf_q <= NB_W'(MAX_BUF));
  a_r5_pad_only_short_crc: assert property (@(posedge clk) disable iff (rst)
    (st == S_PAD) |-> (!nocrc_q && fcnt_q < CNT_W'(PAD_TO)));
  a_r4_no_fcs_without_crc: assert property (@(posedge clk) disable iff (rst)
    (st == S_FCS) |-> !nocrc_q);
  a_r8_stat_single: assert property (@(posedge clk) disable iff (rst)
    stat_valid |=> !stat_valid);
  a_r6_wb_once: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |=> !mem_wr_en);
endmodule

// File: tb/txdesc_walker_tb.sv
module txdesc_walker_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        qptr_wr = 1'b0;
  logic [31:0] qptr_wdata = '0;
  logic [31:0] qptr_rdata;
  logic        start = 1'b0;
  logic        busy;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic [31:0] mem_rd_data = '0;
  logic        mem_wr_en;
  logic [31:0] mem_wr_addr;
  logic [31:0] mem_wr_data;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_last;
  logic        stat_valid;
  logic [1:0]  stat_code;

  always #(CLK_P/2) clk = ~clk;

  txdesc_walker u_dut (
    .clk(clk), .rst(rst), .qptr_wr(qptr_wr), .qptr_wdata(qptr_wdata),
    .qptr_rdata(qptr_rdata), .start(start), .busy(busy),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .stat_valid(stat_valid), .stat_code(stat_code)
  );

  // memory: descriptors below 0x1000, computed buffer pattern above
  logic [31:0] mem [0:1023];
  logic        tb_we = 1'b0;
  logic [9:0]  tb_wa = '0;
  logic [31:0] tb_wd = '0;

  function automatic logic [7:0] patb(input logic [31:0] a);
    return (a[7:0] ^ a[15:8]) + 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_wr_addr[11:2]] <= mem_wr_data;
    if (tb_we)     mem[tb_wa] <= tb_wd;
    if (mem_rd_en) begin
      if (mem_rd_addr >= 32'h1000)
        mem_rd_data <= {patb(mem_rd_addr + 3), patb(mem_rd_addr + 2),
                        patb(mem_rd_addr + 1), patb(mem_rd_addr)};
      else
        mem_rd_data <= mem[mem_rd_addr[11:2]];
    end
  end

  // output collector
  logic [7:0] got [0:4095];
  int   got_n = 0, last_cnt = 0, last_pos = -1;
  logic stat_seen = 1'b0;
  logic [1:0] stat_got = '0;
  logic col_clr = 1'b0;

  always @(negedge clk) begin
    if (col_clr) begin
      got_n = 0; last_cnt = 0; last_pos = -1; stat_seen = 1'b0;
    end else begin
      if (tx_valid) begin
        if (got_n < 4096) got[got_n] = tx_data;
        if (tx_last) begin last_cnt++; last_pos = got_n; end
        got_n++;
      end
      if (stat_valid) begin stat_seen = 1'b1; stat_got = stat_code; end
    end
  end

  int tests = 0, fails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr_word(input logic [31:0] a, input logic [31:0] d);
    tick(); tb_we = 1'b1; tb_wa = a[11:2]; tb_wd = d;
    tick(); tb_we = 1'b0;
  endtask

  function automatic logic [31:0] w1val(input int len, input bit last,
      input bit nocrc, input bit wrap, input bit used);
    return {used, wrap, 13'b0, nocrc, last, 4'b0, 11'(len)};
  endfunction

  task automatic set_desc(input logic [31:0] base, input int idx, input logic [31:0] addr,
      input int len, input bit last, input bit nocrc, input bit wrap, input bit used);
    wr_word(base + 32'(8*idx), addr);
    wr_word(base + 32'(8*idx) + 4, w1val(len, last, nocrc, wrap, used));
  endtask

  task automatic set_qptr(input logic [31:0] a);
    tick(); qptr_wr = 1'b1; qptr_wdata = a;
    tick(); qptr_wr = 1'b0;
  endtask

  task automatic run_frame();
    tick(); col_clr = 1'b1; start = 1'b1;
    tick(); col_clr = 1'b0; start = 1'b0;
    for (int i = 0; i < 20000 && !stat_seen; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(stat_seen, "R3", "completion strobe seen", stat_seen, 1);
  endtask

  // expected stream
  logic [7:0] exb [0:4095];
  int exp_n = 0;

  task automatic exp_fcs();
    logic [31:0] c;
    logic b;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < exp_n; k++)
      for (int j = 0; j < 8; j++) begin
        b = c[0] ^ exb[k][j];
        c = c >> 1;
        if (b) c = c ^ 32'hEDB8_8320;
      end
    c = ~c;
    for (int j = 0; j < 4; j++) begin exb[exp_n] = c[8*j +: 8]; exp_n++; end
  endtask

  task automatic compare_stream(input string req);
    int bad;
    int first;
    bad = 0; first = -1;
    check(got_n == exp_n, req, "byte count", got_n, exp_n);
    for (int k = 0; k < exp_n && k < got_n; k++)
      if (got[k] !== exb[k]) begin
        if (first < 0) first = k;
        bad++;
      end
    check(bad == 0, req, "mismatched bytes (first index)", first, -1);
    if (exp_n > 0)
      check(last_cnt == 1 && last_pos == exp_n - 1, "R3", "tx_last position", last_pos, exp_n - 1);
    else
      check(last_cnt == 0, "R2", "no tx_last on empty frame", last_cnt, 0);
  endtask

  // case table: {nbuf, len0, len1, len2, nocrc, wrap}
  localparam int NCASE = 8;
  localparam logic [36:0] CASES [0:NCASE-1] = '{
    {2'd1, 11'd10, 11'd0,  11'd0,  1'b0, 1'b0},
    {2'd3, 11'd5,  11'd0,  11'd7,  1'b0, 1'b0},
    {2'd1, 11'd70, 11'd0,  11'd0,  1'b1, 1'b0},
    {2'd2, 11'd40, 11'd30, 11'd0,  1'b0, 1'b0},
    {2'd1, 11'd0,  11'd0,  11'd0,  1'b1, 1'b0},
    {2'd2, 11'd3,  11'd60, 11'd0,  1'b1, 1'b1},
    {2'd1, 11'd59, 11'd0,  11'd0,  1'b0, 1'b0},
    {2'd1, 11'd0,  11'd0,  11'd0,  1'b0, 1'b0}
  };

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
    $finish;
  end

  initial begin
    logic [31:0] base;
    repeat (3) tick();
    @(negedge clk);
    check(!tx_valid && !tx_last, "R11", "tx idle in reset", tx_valid, 0);
    check(!stat_valid && !busy, "R11", "status idle in reset", stat_valid, 0);
    tick(); rst = 1'b0;
    @(negedge clk);
    check(qptr_rdata == 0, "R11", "queue pointer after reset", qptr_rdata, 0);

    // table-driven frames
    base = 32'h100;
    for (int c = 0; c < NCASE; c++) begin
      int n, lens[3];
      bit nocrc, wrap;
      logic [31:0] ba[3];
      n = int'(CASES[c][36:35]);
      lens[0] = int'(CASES[c][34:24]);
      lens[1] = int'(CASES[c][23:13]);
      lens[2] = int'(CASES[c][12:2]);
      nocrc = CASES[c][1];
      wrap  = CASES[c][0];
      exp_n = 0;
      for (int i = 0; i < n; i++) begin
        ba[i] = 32'h1000 + 32'(c * 32'h400) + 32'(i * 32'h100) + 32'((c + i) % 4);
        set_desc(base, i, ba[i], lens[i], i == n - 1, (i == 0) && nocrc,
                 (i == n - 1) && wrap, 1'b0);
        for (int k = 0; k < lens[i]; k++) begin exb[exp_n] = patb(ba[i] + 32'(k)); exp_n++; end
      end
      // R1 R4 R5: padding and FCS only when CRC is on
      if (!nocrc) begin
        while (exp_n < 60) begin exb[exp_n] = 8'h00; exp_n++; end
        exp_fcs();
      end
      set_qptr(base);
      run_frame();
      compare_stream(nocrc ? "R4" : "R5");
      check(stat_got == 2'd0, "R1", "status code ok", stat_got, 0);
      // R6 used bits written back
      for (int i = 0; i < n; i++)
        check(mem[(base[11:2]) + 10'(2*i + 1)] == w1val(lens[i], i == n - 1, (i == 0) && nocrc,
              (i == n - 1) && wrap, 1'b1), "R6", "descriptor write-back",
              mem[(base[11:2]) + 10'(2*i + 1)], w1val(lens[i], i == n - 1, (i == 0) && nocrc,
              (i == n - 1) && wrap, 1'b1));
      // R7 pointer advance / wrap
      check(qptr_rdata == (wrap ? base : base + 32'(8 * n)), "R7", "queue pointer after frame",
            qptr_rdata, wrap ? base : base + 32'(8 * n));
    end

    // R8: used descriptor at frame start
    set_desc(32'h200, 0, 32'h1000, 5, 1'b1, 1'b0, 1'b0, 1'b1);
    set_qptr(32'h200);
    run_frame();
    check(stat_got == 2'd1, "R8", "empty code", stat_got, 1);
    check(got_n == 0, "R8", "no bytes on empty queue", got_n, 0);
    check(qptr_rdata == 32'h200, "R8", "pointer unchanged", qptr_rdata, 32'h200);

    // R9: used descriptor mid-frame
    set_desc(32'h300, 0, 32'h1800, 4, 1'b0, 1'b0, 1'b0, 1'b0);
    set_desc(32'h300, 1, 32'h1900, 4, 1'b1, 1'b0, 1'b0, 1'b1);
    set_qptr(32'h300);
    run_frame();
    check(stat_got == 2'd2, "R9", "underrun code", stat_got, 2);
    check(last_cnt == 0, "R9", "no tx_last on aborted frame", last_cnt, 0);
    check(qptr_rdata == 32'h300, "R9", "pointer back to base", qptr_rdata, 32'h300);

    // R10: exactly 128 zero-length buffers, no CRC
    for (int i = 0; i < 128; i++)
      set_desc(32'h0, i, 32'h1000, 0, i == 127, i == 0, 1'b0, 1'b0);
    set_qptr(32'h0);
    run_frame();
    check(stat_got == 2'd0, "R10", "128 buffers accepted", stat_got, 0);
    check(got_n == 0, "R2", "zero-length buffers emit nothing", got_n, 0);
    check(qptr_rdata == 32'd1024, "R7", "pointer after 128 descriptors", qptr_rdata, 1024);

    // R10: 129 buffers
    for (int i = 0; i < 129; i++)
      set_desc(32'h0, i, 32'h1000, 0, i == 128, i == 0, 1'b0, 1'b0);
    set_qptr(32'h0);
    run_frame();
    check(stat_got == 2'd3, "R10", "over-limit code", stat_got, 3);
    check(last_cnt == 0, "R10", "no tx_last on over-limit", last_cnt, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule